// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block watches the demodulated output of an infrared receiver module and records the timing of a remote-control burst. Each mark and each gap is measured in sample ticks and stored as one byte. The bytes are packed four to a 32-bit word in a small capture bank that a host reads through a simple register port. The line is active low: a low level is a mark. It passes through a two-flop synchronizer and then a programmable de-glitch filter before any width is measured.

A capture starts at the first mark after idle. Idle time before that mark is not recorded. Widths that do not fit in a byte are clamped to 0xFF. A gap that outlasts the programmed completion timeout closes the message, sets an interrupt status bit and freezes the bank until the host issues a restart. Protocol decoding is left to software.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0x00 | Control: bit 0 receiver enable, bit 13 width-measurement enable, bits 22:16 timeout |
| 0x04 | Tick divisor: 32 bits |
| 0x08 | Filter: bits 12:8 de-glitch count |
| 0x0C | Interrupt enable: bit 0 |
| 0x10 | Restart: write 1 to bit 0 |
| 0x14 | Status: bit 0 reads the status, writing 1 acknowledges it |
| 0x40 + 4*i | Capture word i, for i = 0..16 |

Top module: `irpw_capture`

## Requirements
- R1: Captured widths fill byte slots in strict alternation, starting with a mark. Slot n sits in capture word n/4 at byte address 0x40 + 4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). Each value is the number of sample ticks the filtered level lasted.
- R2: A mark or a gap longer than 255 ticks is stored as 0xFF and does not wrap.
- R3: Let L be the timeout field (control bits 22:16) times 32 ticks. A gap of exactly L ticks is stored normally. A gap of more than L ticks ends the message: its slot and every later slot read zero, and status bit 0 (address 0x14) becomes 1. No status is raised while every gap is L ticks or shorter.
- R4: The bank holds 68 slots. Transitions after slot 67 is written are dropped, and the stored slots stay unchanged. A gap longer than L still completes the message.
- R5: After reset, control reads 0x00030000, the tick divisor reads 2299, the filter reads 0x00000100, and status and every capture word read 0. Capture runs only when control bits 0 and 13 are both 1. Otherwise input activity leaves the bank and the status at zero.
- R6: A level counts only after it has been seen on D consecutive ticks, where D is filter bits 12:8 (0 acts as 1). A shorter excursion merges into the surrounding level. With D = 1, a one-tick gap is stored as 1.
- R7: Writing 1 to bit 0 at address 0x10 clears all capture words to zero and returns capture to waiting for a mark. This holds in the middle of a message and after a completed one.
- R8: The irq output is high exactly when the status bit and interrupt-enable bit 0 (address 0x0C) are both 1. Writing 1 to bit 0 at 0x14 clears the status.
- R9: Idle time before the first mark is not recorded. After a message completes, further input is not recorded until a restart.
- R10: A sample tick occurs every (divisor + 1) clock cycles. Widths are counted in ticks whatever the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ir_rx_n | input | 1 | Demodulated receiver line, low = mark |
| irq | output | 1 | Interrupt request |

## Verification
A slot index that slips or skips shows up as bytes shifted between slots, or landing in the wrong word, on the first read after the message completes. A miscounted width shows as a wrong byte in that same read. If the completion logic stalls, irq does not rise within L ticks of the last mark. If it fires early, irq rises in the middle of a message and the per-clock monitor catches it on that clock. Tick counts that do not follow the divisor show as widths off by a factor.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
    localparam int ADDR_W         = 8;
    localparam int DATA_W         = 32;
    localparam int SLOT_W         = 8;
    localparam int SLOTS_PER_WORD = DATA_W / SLOT_W;
    localparam int CNT_W          = 16;
    localparam int DG_W           = 5;
    localparam int TO_W           = 7;

    localparam logic [ADDR_W-1:0] A_CONTROL = 8'h00;
    localparam logic [ADDR_W-1:0] A_TICKDIV = 8'h04;
    localparam logic [ADDR_W-1:0] A_FILTER  = 8'h08;
    localparam logic [ADDR_W-1:0] A_IRQEN   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_RESTART = 8'h10;
    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h14;
    localparam logic [ADDR_W-1:0] A_CAPTURE = 8'h40;

    localparam int B_RX_EN = 0;
    localparam int B_PW_EN = 13;
    localparam int B_TO_LO = 16;
    localparam int B_DG_LO = 8;

    localparam logic [TO_W-1:0] TO_RESET = 7'd3;
    localparam logic [DG_W-1:0] DG_RESET = 5'd1;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_RUN,
        CAP_FULL,
        CAP_DONE
    } cap_state_e;

    typedef struct packed {
        logic [TO_W-1:0] timeout;
        logic            pw_en;
        logic            rx_en;
    } ctrl_t;

    // filtered sample stream, one update per tick
    typedef struct packed {
        logic tick;
        logic mark;
        logic toggled;
    } samp_t;

    function automatic logic [SLOT_W-1:0] clamp_width(input logic [CNT_W-1:0] w);
        if (w > CNT_W'({SLOT_W{1'b1}}))
            return {SLOT_W{1'b1}};
        return w[SLOT_W-1:0];
    endfunction
endpackage

// File: rtl/irpw_tick.sv
module irpw_tick #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/irpw_filter.sv
module irpw_filter
    import irpw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_n,
    input  logic            tick,
    input  logic [DG_W-1:0] min_run,
    output samp_t           samp
);
    logic            sync1, sync2;
    logic [DG_W-1:0] run;
    logic [DG_W-1:0] need;
    logic [DG_W:0]   run_nx;

    assign need   = (min_run == '0) ? DG_W'(1) : min_run;
    assign run_nx = {1'b0, run} + (DG_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= ~rx_n;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            samp <= '0;
        end else begin
            samp.tick    <= tick;
            samp.toggled <= 1'b0;
            if (tick) begin
                if (sync2 != samp.mark) begin
                    if (run_nx >= {1'b0, need}) begin
                        samp.mark    <= sync2;
                        samp.toggled <= 1'b1;
                        run          <= '0;
                    end else begin
                        run <= run_nx[DG_W-1:0];
                    end
                end else begin
                    run <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/irpw_engine.sv
module irpw_engine
    import irpw_pkg::*;
#(
    parameter int SLOTS = 68
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         restart,
    input  samp_t                        samp,
    input  logic [CNT_W-1:0]             gap_limit,
    output logic                         done,
    output cap_state_e                   state,
    output logic [SLOTS-1:0][SLOT_W-1:0] slots
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] wnext;
    logic [IDX_W-1:0] idx;

    assign wnext = (wcnt == '1) ? wcnt : wcnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state <= CAP_IDLE;
            wcnt  <= '0;
            idx   <= '0;
            slots <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (samp.tick) begin
                unique case (state)
                    CAP_IDLE: begin
                        if (samp.toggled && samp.mark) begin
                            state <= CAP_RUN;
                            wcnt  <= CNT_W'(1);
                            idx   <= '0;
                        end
                    end
                    CAP_RUN, CAP_FULL: begin
                        if (samp.toggled) begin
                            if (state == CAP_RUN) begin
                                slots[idx] <= clamp_width(wcnt);
                                if (idx == IDX_W'(SLOTS - 1))
                                    state <= CAP_FULL;
                                else
                                    idx <= idx + IDX_W'(1);
                            end
                            wcnt <= CNT_W'(1);
                        end else begin
                            wcnt <= wnext;
                            if (!samp.mark && (wnext > gap_limit)) begin
                                state <= CAP_DONE;
                                done  <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irpw_capture.sv
module irpw_capture
    import irpw_pkg::*;
#(
    parameter int                 NUM_WORDS     = 17,
    parameter int                 GAP_UNIT      = 32,
    parameter logic [DATA_W-1:0]  TICKDIV_RESET = 32'd2299
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ir_rx_n,
    output logic              irq
);
    localparam int SLOTS = NUM_WORDS * SLOTS_PER_WORD;
    localparam int WIX_W = ADDR_W - 2;

    ctrl_t                        ctrl;
    logic [DATA_W-1:0]            tick_div;
    logic [DG_W-1:0]              dg_cnt;
    logic                         irq_en;
    logic                         irq_stat;
    logic                         run_en;
    logic                         tick_raw;
    logic                         restart_p;
    logic                         ack_p;
    logic                         done_p;
    logic [CNT_W-1:0]             gap_limit;
    samp_t                        samp;
    cap_state_e                   cap_st;
    logic [SLOTS-1:0][SLOT_W-1:0] slots;
    logic [ADDR_W-1:0]            woff;
    logic [WIX_W-1:0]             widx;
    int                           sbase;

    assign run_en    = ctrl.rx_en & ctrl.pw_en;
    assign restart_p = reg_we && (reg_addr == A_RESTART) && reg_wdata[0];
    assign ack_p     = reg_we && (reg_addr == A_STATUS) && reg_wdata[0];
    assign gap_limit = CNT_W'(ctrl.timeout) * CNT_W'(GAP_UNIT);
    assign irq       = irq_stat & irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.timeout <= TO_RESET;
            ctrl.pw_en   <= 1'b0;
            ctrl.rx_en   <= 1'b0;
            tick_div     <= TICKDIV_RESET;
            dg_cnt       <= DG_RESET;
            irq_en       <= 1'b0;
            irq_stat     <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    A_CONTROL: begin
                        ctrl.timeout <= reg_wdata[B_TO_LO +: TO_W];
                        ctrl.pw_en   <= reg_wdata[B_PW_EN];
                        ctrl.rx_en   <= reg_wdata[B_RX_EN];
                    end
                    A_TICKDIV: tick_div <= reg_wdata;
                    A_FILTER:  dg_cnt   <= reg_wdata[B_DG_LO +: DG_W];
                    A_IRQEN:   irq_en   <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (done_p)
                irq_stat <= 1'b1;
            else if (ack_p)
                irq_stat <= 1'b0;
        end
    end

    assign woff = reg_addr - A_CAPTURE;
    assign widx = woff[ADDR_W-1:2];

    always_comb begin
        reg_rdata = '0;
        sbase     = int'(widx) * SLOTS_PER_WORD;
        if (reg_addr == A_CONTROL) begin
            reg_rdata[B_RX_EN]            = ctrl.rx_en;
            reg_rdata[B_PW_EN]            = ctrl.pw_en;
            reg_rdata[B_TO_LO +: TO_W]    = ctrl.timeout;
        end else if (reg_addr == A_TICKDIV) begin
            reg_rdata = tick_div;
        end else if (reg_addr == A_FILTER) begin
            reg_rdata[B_DG_LO +: DG_W] = dg_cnt;
        end else if (reg_addr == A_IRQEN) begin
            reg_rdata[0] = irq_en;
        end else if (reg_addr == A_STATUS) begin
            reg_rdata[0] = irq_stat;
        end else if ((reg_addr >= A_CAPTURE) && (woff[1:0] == 2'b00)
                     && (widx < WIX_W'(NUM_WORDS))) begin
            for (int k = 0; k < SLOTS_PER_WORD; k++) begin
                if (sbase + k < SLOTS)
                    reg_rdata[SLOT_W*k +: SLOT_W] = slots[sbase + k];
            end
        end
    end

    irpw_tick #(.DIV_W(DATA_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .enable  (run_en),
        .divisor (tick_div),
        .tick    (tick_raw)
    );

    irpw_filter u_filter (
        .clk     (clk),
        .rst     (rst),
        .rx_n    (ir_rx_n),
        .tick    (tick_raw),
        .min_run (dg_cnt),
        .samp    (samp)
    );

    irpw_engine #(.SLOTS(SLOTS)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart_p),
        .samp      (samp),
        .gap_limit (gap_limit),
        .done      (done_p),
        .state     (cap_st),
        .slots     (slots)
    );
endmodule

// File: rtl/irpw_capture_chk.sv
module irpw_capture_chk
    import irpw_pkg::*;
#(
    parameter int SLOTS = 68
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         run_en,
    input logic                         tick_raw,
    input logic                         restart_p,
    input logic                         ack_p,
    input logic                         done_p,
    input logic                         irq_stat,
    input cap_state_e                   cap_st,
    input logic [SLOTS-1:0][SLOT_W-1:0] slots
);
    AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !tick_raw); // R5

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart_p |=> (slots == '0 && cap_st == CAP_IDLE)); // R7

    AST_IDLE_BANK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (cap_st == CAP_IDLE) |-> (slots == '0)); // R9

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cap_st == CAP_DONE && !restart_p) |=> $stable(slots)); // R9

    AST_FULL_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (cap_st == CAP_FULL && !restart_p) |=> $stable(slots)); // R4

    AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        done_p |=> irq_stat); // R3

    AST_ACK_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (ack_p && !done_p) |=> !irq_stat); // R8
endmodule

bind irpw_capture irpw_capture_chk #(.SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .tick_raw  (tick_raw),
    .restart_p (restart_p),
    .ack_p     (ack_p),
    .done_p    (done_p),
    .irq_stat  (irq_stat),
    .cap_st    (cap_st),
    .slots     (slots)
);

// File: tb/irpw_capture_test.sv
module irpw_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        ir_rx_n = 1'b1;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int  tclk    = 2;
    int  limit_b = 96;
    int  dg_b    = 1;
    bit  en_b    = 1;
    bit  ie_b    = 1;
    bit  mon_on  = 0;
    bit  irq_quiet = 1;
    int  quiet_hits = 0;

    bit  seg_mark[$];
    int  seg_len[$];
    int  exp_slot[68];
    bit  exp_done;

    always #2 clk = ~clk;

    irpw_capture uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ir_rx_n   (ir_rx_n),
        .irq       (irq)
    );

    // per-clock monitor: irq must stay low while the model says no completion yet
    always @(negedge clk) begin
        if (mon_on && irq_quiet && irq === 1'b1)
            quiet_hits++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ctrl(input int timeout, input bit rx, input bit pw);
        wr(8'h00, (32'(timeout) << 16) | (32'(pw) << 13) | 32'(rx));
        limit_b = timeout * 32;
        en_b = rx & pw;
    endtask

    task automatic hold(input bit mark, input int n);
        ir_rx_n = ~mark;
        seg_mark.push_back(mark);
        seg_len.push_back(n);
        repeat (n * tclk) @(negedge clk);
    endtask

    // behavioural model: merge short excursions, skip idle, stop at timeout
    function automatic void model();
        bit fm[$];
        int fl[$];
        bit started;
        int idx;
        for (int i = 0; i < 68; i++) exp_slot[i] = 0;
        exp_done = 0;
        if (!en_b) return;
        for (int i = 0; i < seg_len.size(); i++) begin
            if (fl.size() > 0 && (seg_len[i] < dg_b || fm[fm.size()-1] == seg_mark[i]))
                fl[fl.size()-1] += seg_len[i];
            else begin
                fm.push_back(seg_mark[i]);
                fl.push_back(seg_len[i]);
            end
        end
        started = 0;
        idx = 0;
        for (int i = 0; i < fl.size(); i++) begin
            if (!started && !fm[i]) continue;
            started = 1;
            if (!fm[i] && fl[i] > limit_b) begin
                exp_done = 1;
                return;
            end
            if (i == fl.size() - 1) return;
            if (idx < 68) begin
                exp_slot[idx] = (fl[i] > 255) ? 255 : fl[i];
                idx++;
            end
        end
    endfunction

    task automatic check_msg(input string req);
        logic [31:0] d, e;
        irq_quiet = 0;
        hold(1'b0, limit_b + dg_b + 20);
        model();
        for (int w = 0; w < 17; w++) begin
            rd(8'h40 + 8'(4 * w), d);
            e = {8'(exp_slot[4*w+3]), 8'(exp_slot[4*w+2]),
                 8'(exp_slot[4*w+1]), 8'(exp_slot[4*w])};
            chk(d === e, req, $sformatf("capture word %0d", w), d, e);
        end
        rd(8'h14, d);
        chk(d === {31'b0, exp_done}, "R3", "status after final gap", d, {31'b0, exp_done});
        chk(quiet_hits == 0, "R3", "irq before timeout", 32'(quiet_hits), 32'd0);
        chk(irq === (exp_done & ie_b), "R8", "irq level at end of message",
            {31'b0, irq}, {31'b0, exp_done & ie_b});
    endtask

    task automatic clear_msg();
        logic [31:0] d;
        bit all_zero;
        wr(8'h14, 32'h1);
        rd(8'h14, d);
        chk(d === 32'h0 && irq === 1'b0, "R8", "ack clears status and irq", d, 32'h0);
        wr(8'h10, 32'h1);
        all_zero = 1;
        for (int w = 0; w < 17; w++) begin
            rd(8'h40 + 8'(4 * w), d);
            if (d !== 32'h0) all_zero = 0;
        end
        chk(all_zero, "R7", "restart clears every capture word", {31'b0, all_zero}, 32'h1);
        seg_mark.delete();
        seg_len.delete();
        quiet_hits = 0;
        irq_quiet = 1;
    endtask

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        mon_on = 1;

        // R5 reset values
        chk(irq === 1'b0, "R5", "irq after reset", {31'b0, irq}, 32'h0);
        rd(8'h00, d); chk(d === 32'h0003_0000, "R5", "control reset", d, 32'h0003_0000);
        rd(8'h04, d); chk(d === 32'd2299, "R5", "tick divisor reset", d, 32'd2299);
        rd(8'h08, d); chk(d === 32'h0000_0100, "R5", "filter reset", d, 32'h0000_0100);
        rd(8'h14, d); chk(d === 32'h0, "R5", "status reset", d, 32'h0);
        rd(8'h40, d); chk(d === 32'h0, "R5", "capture word 0 reset", d, 32'h0);

        wr(8'h04, 32'd1);
        tclk = 2;
        wr(8'h0C, 32'h1);
        set_ctrl(3, 1, 1);

        // R1 / R9: long idle before the first mark, mixed widths
        hold(0, 150); hold(1, 9); hold(0, 4); hold(1, 17); hold(0, 30);
        hold(1, 2); hold(0, 60); hold(1, 11);
        check_msg("R1");
        clear_msg();

        // R2: saturation of both a mark and a gap
        set_ctrl(10, 1, 1);
        hold(0, 10); hold(1, 300); hold(0, 280); hold(1, 5);
        check_msg("R2");
        clear_msg();

        // R3 / R9: gap equal to the limit kept, one longer ends the message
        set_ctrl(3, 1, 1);
        hold(0, 10); hold(1, 4); hold(0, 96); hold(1, 6);
        irq_quiet = 0;
        hold(0, 97); hold(1, 8); hold(0, 30); hold(1, 3);
        check_msg("R3");
        clear_msg();

        // R4: more transitions than slots
        hold(0, 10);
        for (int p = 0; p < 40; p++) begin
            hold(1, 3 + (p % 3));
            hold(0, 4);
        end
        check_msg("R4");
        clear_msg();

        // R5: width measurement disabled
        set_ctrl(3, 1, 0);
        hold(0, 10); hold(1, 12); hold(0, 8); hold(1, 6);
        check_msg("R5");
        clear_msg();
        set_ctrl(3, 0, 1);
        hold(0, 10); hold(1, 7); hold(0, 5); hold(1, 9);
        check_msg("R5");
        clear_msg();
        set_ctrl(3, 1, 1);

        // R6: de-glitch count 3 swallows short excursions
        wr(8'h08, 32'd3 << 8);
        dg_b = 3;
        hold(0, 10); hold(1, 10); hold(0, 2); hold(1, 10); hold(0, 5);
        hold(1, 7); hold(0, 1); hold(1, 4);
        check_msg("R6");
        clear_msg();
        wr(8'h08, 32'd1 << 8);
        dg_b = 1;
        hold(0, 10); hold(1, 5); hold(0, 1); hold(1, 5);
        check_msg("R6");
        clear_msg();

        // R7: restart in the middle of a message
        hold(0, 10); hold(1, 5); hold(0, 5); hold(1, 5); hold(0, 3);
        wr(8'h10, 32'h1);
        rd(8'h40, d);
        chk(d === 32'h0, "R7", "word 0 after mid-message restart", d, 32'h0);
        seg_mark.delete();
        seg_len.delete();
        hold(0, 10); hold(1, 6);
        check_msg("R7");
        clear_msg();

        // R10: slower tick, widths still in ticks
        wr(8'h04, 32'd3);
        tclk = 4;
        hold(0, 8); hold(1, 9); hold(0, 4); hold(1, 2);
        check_msg("R10");
        clear_msg();
        wr(8'h04, 32'd1);
        tclk = 2;

        // R8: interrupt enable gates the output
        wr(8'h0C, 32'h0);
        ie_b = 0;
        hold(0, 10); hold(1, 7); hold(0, 3); hold(1, 7);
        check_msg("R8");
        wr(8'h0C, 32'h1);
        ie_b = 1;
        @(negedge clk);
        chk(irq === 1'b1, "R8", "irq after enabling with status set", {31'b0, irq}, 32'h1);
        clear_msg();

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule